// File: doc/BRIEF.md
# Byte-Coherent Timer Counter Reader

This block holds a 16-bit up-counter that a byte-wide register bus reads in two accesses. The first access to either counter byte copies the whole count into a snapshot register. The access to the opposite byte is then served from that copy, so the two bytes always belong to one sample even while the counter keeps moving. Software may read the bytes in either order.

A control register holds a clock-select field. The counter advances on a prescaler tick only while that field is nonzero. A debug-freeze input stops the counter. While it is asserted, a held snapshot is still served, and any register write releases the snapshot. Outside debug, only writes to the counter bytes release it. A write to either counter byte resets the count to zero.

Top module: `tmr_snap_top`

## Requirements
- R1: After a synchronous reset, the count, the control register and the read data are all 0x00/0x0000 and no snapshot is held, so the next counter read samples the live count.
- R2: When debug freeze is low and clock-select (control bits [1:0]) is nonzero, each clock with `tick` high adds one to the count, wrapping from 0xFFFF to 0x0000. With clock-select at 0, or with `tick` low, the count holds.
- R3: When no snapshot is held, a read of the counter high byte (address 1) or low byte (address 2) copies all 16 bits of the current count into the snapshot and returns that byte of the current count.
- R4: While a snapshot is held, a read of the byte opposite to the one that created it returns that byte of the snapshot and releases the snapshot. The next counter read samples afresh.
- R5: While a snapshot is held, a repeated read of the same byte that created it returns that byte of the snapshot and leaves the snapshot held.
- R6: While debug freeze is high, the count does not change, whatever `tick` and clock-select are.
- R7: While debug freeze is high and a snapshot is held, a counter read returns the snapshot byte, not the frozen live count.
- R8: A write to address 1 or address 2 sets the count to 0x0000 and releases any snapshot, in either mode. A write takes precedence over a tick in the same cycle.
- R9: A write to the control register (address 0) releases a held snapshot while debug freeze is high, and leaves the snapshot held while debug freeze is low.
- R10: Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe. Address 0 returns the control register and address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count high, 2 count low, 3 unused |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick | input | 1 | Prescaler tick, counts one when enabled |
| dbg_freeze | input | 1 | Debug freeze: stops the counter and changes the snapshot release rules |

## Verification
Every read result is registered once, so it is due on `bus_rdata` at the first rising edge after the strobe. The bench drives each stimulus at a falling edge and samples one nanosecond after the following rising edge. Count updates, snapshot capture and snapshot release all take effect at that same edge, so a read issued in the next step already sees them. The expected bytes in the vector table and the bench's counter model are derived from these rules. The model counts one per enabled tick step and restarts at zero on a counter write. Two-byte reads taken while the counter runs on every cycle are compared, as one 16-bit word, against the model value at the first read.

// File: rtl/tmr_snap_pkg.sv
`timescale 1ns/1ps
package tmr_snap_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tmr_snap_ctrl.sv
`timescale 1ns/1ps
module tmr_snap_ctrl #(
  parameter int BYTE_W = 8,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              run
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end
  end

  // clock-select field lives in the low bits
  assign run = |ctrl_q[CS_W-1:0];

endmodule

// File: rtl/tmr_snap_counter.sv
`timescale 1ns/1ps
module tmr_snap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             freeze,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic advance;
  assign advance = run && tick && !freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (advance) begin
      count <= count + ONE;
    end
  end

  // R2: an enabled tick moves the count by exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !freeze && !clr) |=> (count == $past(count) + ONE));

  // R2: no tick or no clock select keeps the count
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ((!tick || !run) && !clr) |=> $stable(count));

  // R6: debug freeze holds the count
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clr) |=> $stable(count));

  // R8: a counter write restarts at zero
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

endmodule

// File: rtl/tmr_snap_buffer.sv
`timescale 1ns/1ps
module tmr_snap_buffer #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              clr,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              held
);

  localparam int LANES   = CNT_W / BYTE_W;
  localparam int LANE_HI = LANES - 1;

  logic             first_hi;
  logic [CNT_W-1:0] snap;
  logic [BYTE_W-1:0] lane_src [LANES];

  // each byte lane picks the snapshot while one is held, else the live count
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_src[g] = held ? snap[g*BYTE_W +: BYTE_W]
                              : count[g*BYTE_W +: BYTE_W];
  end

  assign rd_byte = rd_hi ? lane_src[LANE_HI] : lane_src[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      first_hi <= 1'b0;
      snap     <= '0;
    end else if (clr) begin
      held <= 1'b0;
    end else if (rd_hi || rd_lo) begin
      if (!held) begin
        held     <= 1'b1;
        first_hi <= rd_hi;
        snap     <= count;
      end else if (rd_hi != first_hi) begin
        held <= 1'b0;
      end
    end
  end

  // R3: an opening read captures the whole live count
  p_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (!held && (rd_hi || rd_lo) && !clr) |=> (held && snap == $past(count)));

  // R4: the opposite byte completes the pair and releases
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (held && !clr && ((rd_hi && !first_hi) || (rd_lo && first_hi))) |=> !held);

  // R5: the same byte again keeps the snapshot
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (held && !clr && ((rd_hi && first_hi) || (rd_lo && !first_hi)))
      |=> (held && $stable(snap)));

  // R8, R9: a clearing write always releases
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !held);

endmodule

// File: rtl/tmr_snap_top.sv
`timescale 1ns/1ps
module tmr_snap_top #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              dbg_freeze
);

  import tmr_snap_pkg::*;

  reg_sel_e          sel;
  logic              ctrl_wr, cnt_wr, rd_hi, rd_lo, snap_clr;
  logic              run, held;
  logic [BYTE_W-1:0] ctrl_q, cnt_byte;
  logic [CNT_W-1:0]  count;

  assign sel      = reg_sel_e'(bus_addr);
  assign ctrl_wr  = bus_wr && (sel == REG_CTRL);
  assign cnt_wr   = bus_wr && (sel == REG_CNT_HI || sel == REG_CNT_LO);
  assign rd_hi    = bus_rd && (sel == REG_CNT_HI);
  assign rd_lo    = bus_rd && (sel == REG_CNT_LO);
  // counter writes release in any mode, control writes only under debug
  assign snap_clr = cnt_wr || (ctrl_wr && dbg_freeze);

  tmr_snap_ctrl #(.BYTE_W(BYTE_W), .CS_W(CS_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .run(run)
  );

  tmr_snap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .freeze(dbg_freeze),
    .clr(cnt_wr), .count(count)
  );

  tmr_snap_buffer #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst(rst), .rd_hi(rd_hi), .rd_lo(rd_lo), .clr(snap_clr),
    .count(count), .rd_byte(cnt_byte), .held(held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        REG_CTRL:               bus_rdata <= ctrl_q;
        REG_CNT_HI, REG_CNT_LO: bus_rdata <= cnt_byte;
        default:                bus_rdata <= '0;
      endcase
    end
  end

  // R10: the unused address reads as zero one cycle later
  p_none_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == REG_NONE) |=> (bus_rdata == '0));

  // R9: outside debug a control write alone does not release the snapshot
  p_ctl_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (held && ctrl_wr && !dbg_freeze) |=> held);

  // R7: under freeze, a held snapshot is what a counter read returns
  p_dbg_serve_r7: assert property (@(posedge clk) disable iff (rst)
    (dbg_freeze && held && rd_lo && !snap_clr)
      |=> (bus_rdata == $past(u_buf.snap[BYTE_W-1:0])));

endmodule

// File: tb/tmr_snap_top_tb.sv
`timescale 1ns/1ps
module tmr_snap_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0, dbg_freeze = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_snap_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .dbg_freeze(dbg_freeze)
  );

  // op: 0 idle, 1 read, 2 write; addr 0 ctrl, 1 high, 2 low, 3 unused
  function automatic logic [23:0] V(input int op, input int a, input int tk,
                                    input int dg, input int chk, input int wd,
                                    input int ex);
    logic [1:0] o2, a2;
    logic [7:0] w8, e8;
    o2 = op[1:0]; a2 = a[1:0]; w8 = wd[7:0]; e8 = ex[7:0];
    return {o2, a2, tk[0], dg[0], chk[0], 1'b0, w8, e8};
  endfunction

  localparam int NV = 43;
  localparam logic [23:0] VEC [NV] = '{
    V(2,0,0,0,0,8'h01,0),    // 0  set clock select
    V(1,0,0,0,1,0,8'h01),    // 1  R10 ctrl readback
    V(0,0,1,0,0,0,0),        // 2  R2 count 1
    V(0,0,1,0,0,0,0),        // 3  R2 count 2
    V(1,1,1,0,1,0,8'h00),    // 4  R3 high first, snap 2
    V(0,0,1,0,0,0,0),        // 5  count 4
    V(1,2,1,0,1,0,8'h02),    // 6  R4 latched low, release
    V(1,2,0,0,1,0,8'h05),    // 7  R3 low first, snap 5
    V(1,2,1,0,1,0,8'h05),    // 8  R5 same byte again
    V(1,1,0,0,1,0,8'h00),    // 9  R4 release
    V(1,1,1,0,1,0,8'h00),    // 10 R3 snap 6
    V(0,0,1,0,0,0,0),        // 11 count 8
    V(0,0,1,1,0,0,0),        // 12 R6 frozen at 8
    V(1,2,1,1,1,0,8'h06),    // 13 R7 snapshot not frozen count
    V(1,2,0,1,1,0,8'h08),    // 14 R6 fresh latch of frozen 8
    V(2,0,0,1,0,8'h01,0),    // 15 R9 ctrl write in debug clears
    V(0,0,1,0,0,0,0),        // 16 count 9
    V(1,2,0,0,1,0,8'h09),    // 17 R9 fresh, not 08
    V(1,1,0,0,1,0,8'h00),    // 18 release
    V(1,2,0,0,1,0,8'h09),    // 19 snap 9
    V(2,0,1,0,0,8'h01,0),    // 20 R9 ctrl write outside debug, count 10
    V(1,2,0,0,1,0,8'h09),    // 21 R9 still held
    V(1,1,0,0,1,0,8'h00),    // 22 release
    V(1,2,1,0,1,0,8'h0A),    // 23 snap 10
    V(2,1,1,0,0,8'h55,0),    // 24 R8 write high over tick
    V(1,2,0,0,1,0,8'h00),    // 25 R8 count 0, fresh
    V(1,1,0,0,1,0,8'h00),    // 26
    V(0,0,1,0,0,0,0),        // 27
    V(0,0,1,0,0,0,0),        // 28 count 2
    V(1,2,0,0,1,0,8'h02),    // 29 snap 2
    V(2,2,0,1,0,8'hAA,0),    // 30 R8 write low in debug
    V(1,2,0,1,1,0,8'h00),    // 31 R8 fresh 0, not 02
    V(1,1,0,1,1,0,8'h00),    // 32
    V(1,3,0,0,1,0,8'h00),    // 33 R10 unused address
    V(1,0,0,0,1,0,8'h01),    // 34 R10 ctrl
    V(2,0,0,0,0,8'h00,0),    // 35 clock select off
    V(0,0,1,0,0,0,0),        // 36 R2 tick ignored
    V(1,2,0,0,1,0,8'h00),    // 37 R2 still 0
    V(1,1,0,0,1,0,8'h00),    // 38
    V(2,0,0,0,0,8'h02,0),    // 39 other nonzero select
    V(0,0,1,0,0,0,0),        // 40
    V(1,2,0,0,1,0,8'h01),    // 41 R2 counted
    V(1,1,0,0,1,0,8'h00)     // 42
  };

  task automatic step(input int op, input logic [1:0] a, input logic [7:0] wd,
                      input logic tk, input logic dg);
    @(negedge clk);
    bus_rd     = (op == 1);
    bus_wr     = (op == 2);
    bus_addr   = a;
    bus_wdata  = wd;
    tick       = tk;
    dbg_freeze = dg;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %04h expected %04h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] mdl;
    logic [7:0]  hb, lb;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    rst = 1'b0;
    check("R1 rdata after reset", {8'h00, bus_rdata}, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][23:22]), VEC[i][21:20], VEC[i][15:8],
           VEC[i][19], VEC[i][18]);
      if (VEC[i][17])
        check($sformatf("vector %0d", i), {8'h00, bus_rdata}, {8'h00, VEC[i][7:0]});
    end

    // R2 wrap from 0xFFFF to 0
    step(2, 2'd0, 8'h01, 0, 0);
    step(2, 2'd2, 8'h00, 0, 0);
    for (int i = 0; i < 65535; i++) step(0, 0, 0, 1, 0);
    step(1, 2'd2, 0, 0, 0);
    lb = bus_rdata;
    step(1, 2'd1, 0, 0, 0);
    hb = bus_rdata;
    check("R2 count at 0xFFFF", {hb, lb}, 16'hFFFF);
    step(0, 0, 0, 1, 0);
    step(1, 2'd1, 0, 0, 0);
    hb = bus_rdata;
    step(1, 2'd2, 0, 0, 0);
    lb = bus_rdata;
    check("R2 wrap to zero", {hb, lb}, 16'h0000);

    // R3 R4 coherent pairs while the counter runs every cycle
    step(2, 2'd1, 8'h00, 1, 0);
    mdl = 16'h0000;
    for (int i = 0; i < 240; i++) begin
      step(0, 0, 0, 1, 0);
      mdl++;
    end
    for (int k = 0; k < 30; k++) begin
      logic [15:0] at_first;
      at_first = mdl;
      if (k % 2 == 0) step(1, 2'd1, 0, 1, 0);
      else            step(1, 2'd2, 0, 1, 0);
      mdl++;
      if (k % 2 == 0) hb = bus_rdata; else lb = bus_rdata;
      for (int g = 0; g < (k % 4); g++) begin
        step(0, 0, 0, 1, 0);
        mdl++;
      end
      if (k % 2 == 0) step(1, 2'd2, 0, 1, 0);
      else            step(1, 2'd1, 0, 1, 0);
      mdl++;
      if (k % 2 == 0) lb = bus_rdata; else hb = bus_rdata;
      check($sformatf("R3 R4 coherent pair %0d", k), {hb, lb}, at_first);
    end

    // R1 reset releases a held snapshot and clears control
    step(2, 2'd2, 8'h00, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0);
    step(1, 2'd2, 0, 0, 0);
    check("R1 pre-reset snap", {8'h00, bus_rdata}, 16'h000A);
    rst = 1'b1;
    step(0, 0, 0, 0, 0);
    rst = 1'b0;
    check("R1 rdata cleared", {8'h00, bus_rdata}, 16'h0000);
    step(1, 2'd0, 0, 0, 0);
    check("R1 ctrl cleared", {8'h00, bus_rdata}, 16'h0000);
    step(2, 2'd0, 8'h01, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    step(1, 2'd2, 0, 0, 0);
    check("R1 no snapshot after reset", {8'h00, bus_rdata}, 16'h0003);

    step(0, 0, 0, 0, 0);
    finish_run();
  end

endmodule